// File: doc/BRIEF.md
# External Interrupt Edge and Level Detector

This block watches four external interrupt pins and turns qualified events into latched interrupt requests for an 8-bit microcontroller core. All state advances only on cycles where the cycle-rate clock enable `cyc_en` is high. Each pin passes through a two-stage synchroniser before detection. Channels 0 and 1 can fire on a rising edge, a falling edge, a high level or a low level. Channels 2 and 3 can fire on a rising edge, a falling edge or both edges, and each one also gives a one-cycle timer event pulse for every qualified edge. Channel 3 has a digital noise filter. The filter samples either every enabled cycle or every sixteenth one, and it accepts a new level only after two consecutive samples agree.

Software sets up the block through a small register write port. Address 0 holds the trigger modes: two bits per channel, with channel n in bits [2n+1:2n]. Address 1 holds the enables in bits [3:0] and the filter select in bit 4. Writing 1s to address 2 clears the matching request flags. Whenever an enabled flag is pending, the block raises a request and drives the fixed vector of the lowest-numbered such channel.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset all flags are 0, `irq_valid` is 0 and `irq_vector` is 0. All enables are 0 and the filter runs at divide-by-1. Every mode is code 00, so a rising edge on an enabled channel is latched with no mode write.
- R2: Channels 0 and 1 decode their mode as follows: 00 rising edge, 01 falling edge, 10 high level, 11 low level.
- R3: Channels 2 and 3 decode their mode as follows: 00 rising edge, 01 falling edge, 10 or 11 both edges. They never trigger on a level.
- R4: In a level mode, a flag that is cleared while the level is still active sets again on the next enabled cycle. Once the level is inactive, a clear leaves the flag at 0.
- R5: A flag stays set until a write to address 2 with a 1 in its bit position. A 0 in that position leaves the flag unchanged.
- R6: `pend` shows every flag whether or not its channel is enabled. `irq_valid` is high only when at least one flag whose enable bit is set is pending.
- R7: `irq_vector` is 03H, 0BH, 13H or 1BH for channels 0 to 3. It belongs to the lowest-numbered pending, enabled channel, and it is 00H when `irq_valid` is low.
- R8: With filter select 0, channel 3 discards a 1-cycle pin pulse and accepts a 2-cycle pin pulse.
- R9: With filter select 1, channel 3 discards an 8-cycle pin pulse and accepts a 40-cycle pin pulse.
- R10: `tmr_evt[0]` pulses for one enabled cycle on each qualified edge of channel 2, and `tmr_evt[1]` does the same for channel 3.
- R11: No flag is set in a cycle where `cyc_en` is low. A pin pulse that starts and ends while `cyc_en` is low is never seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Cycle-rate clock enable |
| pin_i | input | 4 | Raw external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 mode, 1 enable/filter, 2 clear) |
| wr_data | input | 8 | Register write data |
| pend | output | 4 | Latched request flags |
| irq_valid | output | 1 | An enabled request is pending |
| irq_vector | output | 8 | Vector of the winning request |
| tmr_evt | output | 2 | Timer event pulses from channels 2 and 3 |

## Verification
The hardest case to reach from the ports is the divide-by-16 filter. Whether a pulse is kept depends on where the hidden sample counter stands when the pulse arrives. The stimulus therefore uses pulse lengths that give the same result at any counter phase: 8 cycles can span at most one sample, and 40 cycles always span two. The bench also reaches level-mode re-assertion by clearing a flag while its level is held active. Randomized trials cover every mode of every channel against all four old and new pin levels.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   typedef enum logic [1:0] {
      TRG_RISE = 2'b00,
      TRG_FALL = 2'b01,
      TRG_HIGH = 2'b10,
      TRG_LOW  = 2'b11
   } trig_mode_e;

   localparam int ADDR_MODE = 0;
   localparam int ADDR_CTRL = 1;
   localparam int ADDR_CLR  = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         chain_q <= '0;
      else if (en)
         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter #(
   parameter int DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic slow_sel,
   input  logic d,
   output logic q
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

   logic [CW-1:0] div_cnt_q;
   logic          smp_q;
   logic          out_q;
   logic          tick;

   assign tick = en && (!slow_sel || (div_cnt_q == '0));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt_q <= '0;
         smp_q     <= 1'b0;
         out_q     <= 1'b0;
      end else begin
         if (en)
            div_cnt_q <= (div_cnt_q == CW'(DIV-1)) ? '0 : div_cnt_q + 1'b1;
         if (tick) begin
            smp_q <= d;
            if (d == smp_q)
               out_q <= d;
         end
      end
   end

   assign q = out_q;
endmodule

// File: rtl/ext_irq_trig.sv
module ext_irq_trig
   import ext_irq_pkg::*;
#(
   parameter bit LEVEL_OK = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       d,
   input  logic [1:0] mode,
   output logic       set
);
   logic prev_q;
   logic rise, fall, hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= 1'b0;
      else if (en)
         prev_q <= d;
   end

   assign rise = d & ~prev_q;
   assign fall = ~d & prev_q;

   generate
      if (LEVEL_OK) begin : g_level_type
         always_comb begin
            case (trig_mode_e'(mode))
               TRG_RISE: hit = rise;
               TRG_FALL: hit = fall;
               TRG_HIGH: hit = d;
               default:  hit = ~d;
            endcase
         end
      end else begin : g_edge_type
         always_comb begin
            if (mode[1])
               hit = rise | fall;
            else if (mode[0])
               hit = fall;
            else
               hit = rise;
         end
      end
   endgenerate

   assign set = en & hit;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
   import ext_irq_pkg::*;
#(
   parameter int         NUM_CH      = 4,
   parameter int         LEVEL_CH    = 2,
   parameter int         FILT_CH     = 3,
   parameter int         FILT_DIV    = 16,
   parameter int         SYNC_STAGES = 2,
   parameter int         DW          = 8,
   parameter int         AW          = 2,
   parameter logic [7:0] VEC_BASE    = 8'h03,
   parameter int         VEC_STEP    = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cyc_en,
   input  logic [NUM_CH-1:0]      pin_i,
   input  logic                   wr_en,
   input  logic [AW-1:0]          wr_addr,
   input  logic [DW-1:0]          wr_data,
   output logic [NUM_CH-1:0]      pend,
   output logic                   irq_valid,
   output logic [7:0]             irq_vector,
   output logic [NUM_CH-LEVEL_CH-1:0] tmr_evt
);
   localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int MW = 2 * NUM_CH;

   generate
      if (NUM_CH < 2 || NUM_CH > 8) begin : g_bad_num_ch
         $error("NUM_CH must be 2..8");
      end
      if (LEVEL_CH >= NUM_CH) begin : g_bad_level_ch
         $error("LEVEL_CH must be below NUM_CH");
      end
      if (FILT_CH >= NUM_CH) begin : g_bad_filt_ch
         $error("FILT_CH must name an existing channel");
      end
      if (MW > DW || NUM_CH + 1 > DW) begin : g_bad_dw
         $error("DW too narrow for mode or control fields");
      end
      if (SYNC_STAGES < 2 || FILT_DIV < 2) begin : g_bad_depth
         $error("SYNC_STAGES and FILT_DIV must be at least 2");
      end
   endgenerate

   logic [MW-1:0]     mode_q;
   logic [NUM_CH-1:0] en_q;
   logic              slow_q;
   logic [NUM_CH-1:0] pend_q;
   logic [NUM_CH-1:0] set_vec;
   logic [NUM_CH-1:0] clr_mask;
   logic [NUM_CH-1:0] live;
   logic [IW-1:0]     win;
   logic              any;

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         en_q   <= '0;
         slow_q <= 1'b0;
      end else if (wr_en) begin
         if (wr_addr == AW'(ADDR_MODE))
            mode_q <= wr_data[MW-1:0];
         if (wr_addr == AW'(ADDR_CTRL)) begin
            en_q   <= wr_data[NUM_CH-1:0];
            slow_q <= wr_data[NUM_CH];
         end
      end
   end

   // per-channel front end
   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
         logic synced;
         logic cleaned;

         ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cyc_en),
            .d     (pin_i[ch]),
            .q     (synced)
         );

         if (ch == FILT_CH) begin : g_filt
            ext_irq_filter #(.DIV(FILT_DIV)) u_filt (
               .clk      (clk),
               .rst_n    (rst_n),
               .en       (cyc_en),
               .slow_sel (slow_q),
               .d        (synced),
               .q        (cleaned)
            );
         end else begin : g_nofilt
            assign cleaned = synced;
         end

         ext_irq_trig #(.LEVEL_OK(ch < LEVEL_CH)) u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (cyc_en),
            .d     (cleaned),
            .mode  (mode_q[2*ch +: 2]),
            .set   (set_vec[ch])
         );

         if (ch >= LEVEL_CH) begin : g_tmr
            assign tmr_evt[ch-LEVEL_CH] = set_vec[ch];
         end
      end
   endgenerate

   // request flags: a new event outranks a simultaneous clear
   assign clr_mask = (wr_en && wr_addr == AW'(ADDR_CLR)) ? wr_data[NUM_CH-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else
         pend_q <= (pend_q & ~clr_mask) | set_vec;
   end

   // fixed priority, lowest channel wins
   assign live = pend_q & en_q;

   always_comb begin
      win = '0;
      any = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (live[i]) begin
            win = IW'(i);
            any = 1'b1;
         end
      end
   end

   assign pend       = pend_q;
   assign irq_valid  = any;
   assign irq_vector = any ? (VEC_BASE + 8'(int'(win) * VEC_STEP)) : 8'h00;
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
   parameter int         NUM_CH   = 4,
   parameter int         LEVEL_CH = 2,
   parameter int         AW       = 2,
   parameter int         DW       = 8,
   parameter logic [7:0] VEC_BASE = 8'h03
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cyc_en,
   input logic                       wr_en,
   input logic [AW-1:0]              wr_addr,
   input logic [DW-1:0]              wr_data,
   input logic [NUM_CH-1:0]          pend,
   input logic [NUM_CH-1:0]          en_q,
   input logic                       irq_valid,
   input logic [7:0]                 irq_vector,
   input logic [NUM_CH-LEVEL_CH-1:0] tmr_evt
);
   // R7: vector is zero while no request is raised
   p_vec_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid |-> (irq_vector == 8'h00));

   // R7: channel 0 pending and enabled always wins
   p_ch0_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[0] && en_q[0]) |-> (irq_valid && irq_vector == VEC_BASE));

   // R6: a raised request implies an enabled pending flag
   p_valid_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> ((pend & en_q) != '0));

   // R5: flags never fall without a clear write
   p_no_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == AW'(2)) |=> ((pend & $past(pend)) == $past(pend)));

   // R11: no new flag from a cycle with the enable low
   p_no_set_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_en |=> ((pend & ~$past(pend)) == '0));

   // R10: timer pulses only in enabled cycles
   p_tmr_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_evt != '0) |-> cyc_en);
endmodule

bind ext_irq_detect ext_irq_detect_chk #(
   .NUM_CH   (NUM_CH),
   .LEVEL_CH (LEVEL_CH),
   .AW       (AW),
   .DW       (DW),
   .VEC_BASE (VEC_BASE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_en     (cyc_en),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .pend       (pend),
   .en_q       (en_q),
   .irq_valid  (irq_valid),
   .irq_vector (irq_vector),
   .tmr_evt    (tmr_evt)
);

// File: tb/ext_irq_detect_tb.sv
module ext_irq_detect_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b1;
   logic [3:0] pin_i = '0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [3:0] pend;
   logic       irq_valid;
   logic [7:0] irq_vector;
   logic [1:0] tmr_evt;

   int n_tests = 0;
   int n_fail = 0;
   int tcnt2 = 0;
   int tcnt3 = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ext_irq_detect dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_en     (cyc_en),
      .pin_i      (pin_i),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .pend       (pend),
      .irq_valid  (irq_valid),
      .irq_vector (irq_vector),
      .tmr_evt    (tmr_evt)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         tcnt2 = tcnt2 + int'(tmr_evt[0]);
         tcnt3 = tcnt3 + int'(tmr_evt[1]);
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic bit exp_flag(input int ch, input int mode, input bit o, input bit n);
      if (ch < 2) begin
         case (mode)
            0: return !o && n;
            1: return o && !n;
            2: return o || n;
            default: return !o || !n;
         endcase
      end
      case (mode)
         0: return !o && n;
         1: return o && !n;
         default: return o != n;
      endcase
   endfunction

   initial begin
      void'($urandom(32'h5EED));
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R1 reset state
      check("R1 pend", pend, 0);
      check("R1 irq_valid", irq_valid, 0);
      check("R1 vector", irq_vector, 0);

      // R1 default rising mode, enable channels
      wr(1, 8'h0F);
      pin_i[1] = 1'b1;
      wait_cyc(6);
      check("R1 default rising ch1", pend, 4'b0010);
      check("R7 vector ch1", irq_vector, 8'h0B);

      // R6 disabled channel still shows pending
      wr(1, 8'h0D);
      check("R6 irq_valid off", irq_valid, 0);
      check("R6 pend kept", pend[1], 1);
      wr(1, 8'h0F);

      // R7 priority ch1 over ch3
      pin_i[3] = 1'b1;
      wait_cyc(8);
      check("R7 priority", irq_vector, 8'h0B);
      wr(2, 8'h02);
      wait_cyc(1);
      check("R7 vector ch3", irq_vector, 8'h1B);
      wr(2, 8'h00);
      wait_cyc(1);
      check("R5 zero write ignored", pend, 4'b1000);
      wr(2, 8'h0F);
      wait_cyc(1);
      check("R5 clear", pend, 0);
      pin_i = '0;
      wait_cyc(8);
      wr(2, 8'h0F);

      // R4 level re-assert on ch0 high level
      wr(0, 8'h02);
      pin_i[0] = 1'b1;
      wait_cyc(6);
      check("R4 level set", pend[0], 1);
      wr(2, 8'h01);
      wait_cyc(2);
      check("R4 re-assert", pend[0], 1);
      pin_i[0] = 1'b0;
      wait_cyc(6);
      wr(2, 8'h01);
      wait_cyc(4);
      check("R4 level gone", pend[0], 0);
      wr(0, 8'h00);
      wait_cyc(2);
      wr(2, 8'h0F);

      // R11 pulse hidden while cycle enable is low
      cyc_en = 1'b0;
      pin_i[0] = 1'b1;
      wait_cyc(5);
      check("R11 no set when idle", pend[0], 0);
      pin_i[0] = 1'b0;
      wait_cyc(2);
      cyc_en = 1'b1;
      wait_cyc(10);
      check("R11 pulse unseen", pend[0], 0);

      // R10 both edges on ch2 with timer pulses
      wr(0, 8'h20);
      wr(2, 8'h0F);
      tcnt2 = 0;
      for (int k = 0; k < 3; k++) begin
         pin_i[2] = ~pin_i[2];
         wait_cyc(6);
      end
      check("R10 ch2 timer pulses", tcnt2, 3);
      check("R3 both edges flag", pend[2], 1);
      pin_i[2] = 1'b0;
      wait_cyc(6);
      wr(0, 8'h00);
      wr(2, 8'h0F);

      // R8 filter divide-by-1
      tcnt3 = 0;
      pin_i[3] = 1'b1; wait_cyc(1); pin_i[3] = 1'b0;
      wait_cyc(12);
      check("R8 1-cycle rejected", pend[3], 0);
      pin_i[3] = 1'b1; wait_cyc(2); pin_i[3] = 1'b0;
      wait_cyc(12);
      check("R8 2-cycle accepted", pend[3], 1);
      check("R10 ch3 timer pulse", tcnt3, 1);
      wr(2, 8'h0F);

      // R9 filter divide-by-16
      wr(1, 8'h1F);
      pin_i[3] = 1'b1; wait_cyc(8); pin_i[3] = 1'b0;
      wait_cyc(70);
      check("R9 8-cycle rejected", pend[3], 0);
      pin_i[3] = 1'b1; wait_cyc(40); pin_i[3] = 1'b0;
      wait_cyc(70);
      check("R9 40-cycle accepted", pend[3], 1);
      wr(1, 8'h0F);
      wr(2, 8'h0F);

      // R2 R3 random trials
      for (int t = 0; t < 60; t++) begin
         int ch, md;
         bit o, n;
         logic [7:0] modes;
         ch = int'($urandom_range(0, 3));
         md = (ch < 2) ? int'($urandom_range(0, 3)) : int'($urandom_range(0, 3));
         o = 1'($urandom_range(0, 1));
         n = 1'($urandom_range(0, 1));
         modes = 8'($urandom);
         modes[2*ch +: 2] = 2'(md);
         wr(0, modes);
         pin_i[ch] = o;
         wait_cyc(10);
         wr(2, 8'h0F);
         pin_i[ch] = n;
         wait_cyc(12);
         if (ch < 2)
            check($sformatf("R2 ch%0d mode%0d %0b->%0b", ch, md, o, n), pend[ch], exp_flag(ch, md, o, n));
         else
            check($sformatf("R3 ch%0d mode%0d %0b->%0b", ch, md, o, n), pend[ch], exp_flag(ch, md, o, n));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule